// File: doc/BRIEF.md
# SD Card SPI Command Frame Transmitter

This host-side block assembles one six-byte SD memory card command and shifts it out over an SPI link in mode 0. A command is offered as a 6-bit command index and a 32-bit argument on a valid/ready handshake. When a command is taken, the block lowers chip select and drives the frame onto MOSI, most significant bit first. A clock divider generates SCLK from the system clock. The frame is made of a start/direction header with the index, the argument, and a final byte that carries a 7-bit CRC plus an end bit.

The command input follows valid/ready rules. `cmd_ready` is high only while no frame is in flight. A command is taken on a rising system-clock edge that sees both `cmd_valid` and `cmd_ready` high. While a frame is being sent, `cmd_ready` stays low. A request held or pulsed during that time does not change the frame on the wire and is not remembered. The source may hold `cmd_valid` and the payload until the next handshake. `frame_done` pulses for one cycle when the frame is over, and a waiting request can be taken in that same cycle.

Top module: `sd_cmd_frame_tx`

## Requirements
- R1: The first byte on the wire is binary `01` followed by the 6-bit command index (bit 47 = 0, bit 46 = 1, bits 45:40 = index).
- R2: Bytes two to five carry the 32-bit argument, most significant byte first (frame bits 39:8).
- R3: The last byte is a 7-bit CRC shifted left by one with bit 0 set to 1. The CRC uses the polynomial x^7 + x^3 + 1, starts at zero, and runs over the 40 preceding bits MSB first. Index 0 with a zero argument produces 40 00 00 00 00 95.
- R4: SPI mode 0. SCLK is low whenever chip select is high. MOSI only changes while SCLK is low, and it holds steady through every SCLK high phase. The receiver samples on the rising edge.
- R5: Each SCLK half period lasts `SCLK_HALF_DIV` system cycles. The first rising edge comes `SCLK_HALF_DIV` cycles after chip select falls. Chip select stays low for `96*SCLK_HALF_DIV + 1` cycles per frame.
- R6: One chip-select assertion contains exactly 48 SCLK rising edges, a whole number of bytes.
- R7: `cmd_ready` is high only when idle. A valid request while busy leaves the frame on the wire unchanged and starts no later frame once it is withdrawn.
- R8: `frame_done` is a one-cycle pulse that comes in the same cycle that chip select returns high, after the last falling SCLK edge.
- R9: After reset, chip select is high, SCLK and MOSI are low, `cmd_ready` is high and `frame_done` is low.
- R10: A request held across the end of a frame is taken in the `frame_done` cycle. Chip select is then high for exactly one system cycle between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the card |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The end of a frame (`frame_done` with chip select rising) and the taking of a new command can happen in the same cycle. The bench provokes this by holding `cmd_valid` high with a second command while the first frame is still going out. It then checks that chip select was high for exactly one sampled cycle between the frames and that `frame_done` came with the rise. It also checks that the second frame arrives bit-exact, with its own CRC byte and 48 rising edges.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int unsigned CRC_W    = 7;
  localparam logic [6:0]  CRC_POLY = 7'h09;  // x^7 + x^3 + 1
  localparam logic [1:0]  HDR_LEAD = 2'b01;  // start bit 0, host bit 1

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_FIN   = 2'd2
  } sdf_state_e;
endpackage

// File: rtl/sdf_frame_build.sv
module sdf_frame_build
  import sdf_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned ARG_W = 32,
  localparam int unsigned HDR_W = 2 + IDX_W + ARG_W,
  localparam int unsigned FRM_W = HDR_W + CRC_W + 1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic [FRM_W-1:0] frame
);
  logic [HDR_W-1:0] hdr;
  logic [CRC_W-1:0] stage [HDR_W+1];

  assign hdr      = {HDR_LEAD, idx, arg};
  assign stage[0] = '0;

  // One bit-serial CRC step per header bit, MSB first, unrolled.
  for (genvar g = 0; g < HDR_W; g++) begin : g_crc
    logic fb;
    assign fb         = hdr[HDR_W-1-g] ^ stage[g][CRC_W-1];
    assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  assign frame = {hdr, stage[HDR_W], 1'b1};
endmodule

// File: rtl/sdf_clkdiv.sv
module sdf_clkdiv #(
  parameter int unsigned HALF_DIV = 2,
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(HALF_DIV - 1));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (at_end)    cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(HALF_DIV - 1)); // R5
endmodule

// File: rtl/sdf_shifter.sv
module sdf_shifter #(
  parameter int unsigned FRM_W = 48,
  localparam int unsigned BW = $clog2(FRM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [FRM_W-1:0] load_data,
  input  logic             shift,
  output logic             out_bit,
  output logic             last
);
  logic [FRM_W-1:0] sreg;
  logic [BW-1:0]    bit_cnt;

  assign out_bit = sreg[FRM_W-1];
  assign last    = (bit_cnt == BW'(FRM_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg    <= '0;
      bit_cnt <= '0;
    end else if (load) begin
      sreg    <= load_data;
      bit_cnt <= '0;
    end else if (shift) begin
      sreg    <= {sreg[FRM_W-2:0], 1'b0};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= BW'(FRM_W - 1)); // R6
  AST_NO_SHIFT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !last); // R6
  AST_NO_LOAD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift)); // R7
endmodule

// File: rtl/sd_cmd_frame_tx.sv
module sd_cmd_frame_tx
  import sdf_pkg::*;
#(
  parameter int unsigned IDX_W         = 6,
  parameter int unsigned ARG_W         = 32,
  parameter int unsigned SCLK_HALF_DIV = 2,
  localparam int unsigned FRM_W = 2 + IDX_W + ARG_W + CRC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [ARG_W-1:0] cmd_arg,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  output logic             frame_done
);
  sdf_state_e       state;
  logic             cs_n_q, sclk_q, done_q;
  logic             tick, last, out_bit;
  logic             take, shift_now;
  logic [FRM_W-1:0] frame_w;

  sdf_frame_build #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_build (
    .idx   (cmd_index),
    .arg   (cmd_arg),
    .frame (frame_w)
  );

  sdf_clkdiv #(.HALF_DIV(SCLK_HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_SHIFT),
    .tick  (tick)
  );

  assign take      = (state == ST_IDLE) && cmd_valid;
  assign shift_now = (state == ST_SHIFT) && tick && sclk_q && !last;

  sdf_shifter #(.FRM_W(FRM_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take),
    .load_data (frame_w),
    .shift     (shift_now),
    .out_bit   (out_bit),
    .last      (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            cs_n_q <= 1'b0;
            sclk_q <= 1'b0;
            state  <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            if (sclk_q && last) state <= ST_FIN;
          end
        end
        ST_FIN: begin
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state == ST_IDLE);
  assign spi_cs_n   = cs_n_q;
  assign spi_sclk   = sclk_q;
  assign spi_mosi   = !cs_n_q && out_bit;
  assign frame_done = done_q;

  AST_CS_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R4
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R8
  AST_DONE_WITH_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (spi_cs_n && !spi_sclk)); // R8
  AST_BUSY_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> !spi_cs_n); // R7
  AST_TAKE_LOWERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!spi_cs_n && !spi_sclk)); // R10
endmodule

// File: tb/sd_cmd_frame_tx_test.sv
module sd_cmd_frame_tx_test;
  localparam int HALF = 3;
  localparam int NV   = 6;
  // {index, argument, expected last byte}
  localparam logic [45:0] VEC [NV] = '{
    {6'd0,  32'h0000_0000, 8'h95},
    {6'd8,  32'h0000_01AA, 8'h87},
    {6'd17, 32'h0000_0000, 8'h55},
    {6'd55, 32'h0000_0000, 8'h65},
    {6'd41, 32'h4000_0000, 8'h77},
    {6'd58, 32'h0000_0000, 8'hFD}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [5:0] cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic cmd_ready, spi_cs_n, spi_sclk, spi_mosi, frame_done;

  always #5 clk = ~clk;

  sd_cmd_frame_tx #(.SCLK_HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .frame_done(frame_done)
  );

  int checks = 0, failures = 0, cyc = 0;

  // Port monitor, sampled on falling system-clock edges.
  logic [47:0] cap = '0, last_frame = '0;
  int nbits = 0, last_bits = 0, low_cyc = 0, last_low = 0;
  int hi_cyc = 0, last_hi = 0, frames = 0, dones = 0;
  int rise_gap = 0, rise_err = 0, stab_err = 0, idle_err = 0;
  logic done_at_rise = 1'b0;
  logic sclk_q = 1'b0, mosi_q = 1'b0, cs_q = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!spi_cs_n) begin
        if (cs_q) begin last_hi = hi_cyc; hi_cyc = 0; end
        low_cyc++;
        rise_gap++;
        if (spi_sclk && !sclk_q) begin
          if (nbits > 0 && rise_gap != 2 * HALF) rise_err++;
          if (nbits == 0 && rise_gap != HALF + 1) rise_err++;
          cap = {cap[46:0], spi_mosi};
          nbits++;
          rise_gap = 0;
        end
        if (spi_sclk && sclk_q && spi_mosi != mosi_q) stab_err++;
      end else begin
        hi_cyc++;
        if (spi_sclk) idle_err++;
        if (!cs_q) begin
          last_frame = cap; last_bits = nbits; last_low = low_cyc;
          done_at_rise = frame_done;
          frames++;
          cap = '0; nbits = 0; low_cyc = 0; rise_gap = 0;
        end
      end
      if (frame_done) dones++;
      sclk_q = spi_sclk; mosi_q = spi_mosi; cs_q = spi_cs_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic offer(input logic [5:0] idx, input logic [31:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = idx; cmd_arg = arg;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    while (frames < target) @(posedge clk);
  endtask

  task automatic check_frame(input logic [5:0] idx, input logic [31:0] arg,
                             input logic [7:0] crc_byte);
    chk(last_frame[47:40] == {2'b01, idx}, "R1", "first byte",
        64'(last_frame[47:40]), 64'({2'b01, idx}));
    chk(last_frame[39:8] == arg, "R2", "argument bytes",
        64'(last_frame[39:8]), 64'(arg));
    chk(last_frame[7:0] == crc_byte, "R3", "crc byte",
        64'(last_frame[7:0]), 64'(crc_byte));
    chk(last_bits == 48, "R6", "rising edges per frame", 64'(last_bits), 64'd48);
    chk(last_low == 96 * HALF + 1, "R5", "cs low cycles",
        64'(last_low), 64'(96 * HALF + 1));
    chk(done_at_rise, "R8", "done with cs rise", 64'(done_at_rise), 64'd1);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R9: reset state, while in reset and just after.
    chk(spi_cs_n == 1'b1, "R9", "cs_n in reset", 64'(spi_cs_n), 64'd1);
    chk(spi_sclk == 1'b0, "R9", "sclk in reset", 64'(spi_sclk), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "ready after reset", 64'(cmd_ready), 64'd1);
    chk(frame_done == 1'b0 && spi_mosi == 1'b0, "R9", "done/mosi after reset",
        64'({frame_done, spi_mosi}), 64'd0);

    // Table walk: R1 R2 R3 R5 R6 R8 per vector.
    for (int v = 0; v < NV; v++) begin
      base = frames;
      offer(VEC[v][45:40], VEC[v][39:8]);
      wait_frames(base + 1);
      check_frame(VEC[v][45:40], VEC[v][39:8], VEC[v][7:0]);
    end
    chk(dones == NV, "R8", "done pulse count", 64'(dones), 64'(NV));
    chk(stab_err == 0, "R4", "mosi moved while sclk high", 64'(stab_err), 64'd0);
    chk(idle_err == 0, "R4", "sclk high with cs high", 64'(idle_err), 64'd0);
    chk(rise_err == 0, "R5", "sclk edge spacing", 64'(rise_err), 64'd0);

    // R7: request while busy is not taken and does not disturb the frame.
    base = frames;
    offer(6'd13, 32'hDEAD_BEEF);
    repeat (20) @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 6'h3F; cmd_arg = 32'h1234_5678;
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R7", "ready while busy", 64'(cmd_ready), 64'd0);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_frames(base + 1);
    chk(last_frame[47:8] == {2'b01, 6'd13, 32'hDEAD_BEEF}, "R7", "frame under busy request",
        64'(last_frame[47:8]), 64'({2'b01, 6'd13, 32'hDEAD_BEEF}));
    repeat (400) @(negedge clk);
    chk(frames == base + 1 && spi_cs_n, "R7", "no frame from dropped request",
        64'(frames), 64'(base + 1));

    // R10: second request held across the end of the first frame.
    base = frames;
    offer(6'd0, 32'h0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 6'd8; cmd_arg = 32'h0000_01AA;
    while (!cmd_ready) @(negedge clk);
    chk(frame_done == 1'b1, "R10", "take in done cycle", 64'(frame_done), 64'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_frames(base + 2);
    check_frame(6'd8, 32'h0000_01AA, 8'h87);
    chk(last_hi == 1, "R10", "cs high gap between frames", 64'(last_hi), 64'd1);
    chk(stab_err == 0, "R4", "mosi hold across back-to-back", 64'(stab_err), 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule